// File: doc/BRIEF.md
# Latched one-of-eight address decoder

This block turns a 3-bit binary address into an 8-bit select vector in which exactly one line is active. In front of the decoder sits an address hold stage. While the hold control is low, the hold stage is transparent and the decoder follows the live address. While the hold control is high, the decoder keeps using the address that was captured at the last clock edge on which the hold control was low. Two enables of opposite polarity act after the hold stage and are never captured, so a held address can be gated on and off freely.

A parameter chooses the output polarity. The output is either one-hot, with the selected line high, or one-cold, with the selected line low. The block can serve as a plain decoder or as a chip-select generator that keeps its address. It can also act as a 1-to-8 demultiplexer: one enable carries the data and the other is held asserted. Several copies can be cascaded into wider decoders by driving their enables from the upper address bits.

Top module: `latched_sel_decoder`

## Requirements
- R1: While `hold_i` is low, the decoder uses `addr_i` directly, so a change of `addr_i` shows on `sel_o` in the same cycle.
- R2: While `hold_i` is high, the decoder uses the address registered at the most recent rising clock edge on which `hold_i` was low, and changes of `addr_i` have no effect on `sel_o`.
- R3: When `en_n_i` is 1 or `en_i` is 0, every bit of `sel_o` is at its inactive level, whatever the values of `addr_i` and `hold_i`.
- R4: The enables are not registered. Deasserting either enable idles `sel_o` in the same cycle even while an address is held, and asserting both again shows the held address without a clock edge.
- R5: With `en_n_i` = 0 and `en_i` = 1, exactly one bit of `sel_o` is active, and its index is the binary value of the selected address, with bit 0 as the least significant bit.
- R6: Parameter `POLARITY` = `POL_HIGH` (enum value 1) makes the active level 1 and the idle level 0. `POL_LOW` (value 0) makes the active level 0 and the idle level 1.
- R7: With `en_n_i` held at 0 and data driven on `en_i`, the selected line copies the data (inverted when `POLARITY` is `POL_LOW`) and all other lines stay idle.
- R8: A synchronous `rst` clears the held address to 0. Reset does not force `sel_o`, which still follows the enables and the selected address while reset is asserted.
- R9: Four copies, each with one enable driven from address bit 3 and the other from address bit 4, form a 1-of-32 decoder in which exactly the line addressed by the 5-bit value is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address hold register |
| rst | input | 1 | Synchronous active-high reset; clears the held address |
| addr_i | input | ADDR_W | Binary address to decode |
| hold_i | input | 1 | 1 = use the held address; 0 = transparent |
| en_n_i | input | 1 | Active-low enable |
| en_i | input | 1 | Active-high enable |
| sel_o | output | 2**ADDR_W | Decoded select vector |

## Verification
The bench changes the address while the hold control is high. A design that keeps loading the register would let the output move, and one that samples the address late would show the wrong line. It drops each enable in turn while an address is held. This catches an enable that has been captured into the register, which would let the output lag by a cycle. It also catches gating applied before the hold stage, which would lose the held address. Reset is applied with the hold control high to show that the held address becomes 0, and with it low to show that reset does not blank the output. A demultiplexer sweep, a one-cold copy and a 32-line cascade expose inverted polarity and a wrong bit order in the address.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} polarity_e;
  parameter int unsigned DEF_ADDR_W = 3;
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (!hold_i) held_q <= addr_i;
  end

  assign eff_addr_o = hold_i ? held_q : addr_i;

  // R2: register is frozen across consecutive holding cycles
  assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_i && $past(hold_i) && !$past(rst)) |-> $stable(held_q));
endmodule

// File: rtl/onehot_decode.sv
module onehot_decode #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [OUT_N-1:0]  hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot_o[i] = en_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/sel_polarity.sv
module sel_polarity
  import addr_dec_pkg::*;
#(
  parameter int unsigned OUT_N = 8,
  parameter polarity_e POLARITY = POL_HIGH
) (
  input  logic [OUT_N-1:0] hot_i,
  output logic [OUT_N-1:0] sel_o
);
  if (POLARITY == POL_HIGH) begin : g_high
    assign sel_o = hot_i;
  end else begin : g_low
    assign sel_o = ~hot_i;
  end
endmodule

// File: rtl/latched_sel_decoder.sv
module latched_sel_decoder
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter polarity_e POLARITY = POL_HIGH,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  input  logic              en_n_i,
  input  logic              en_i,
  output logic [OUT_N-1:0]  sel_o
);
  localparam logic ON_LVL = (POLARITY == POL_HIGH);
  localparam logic [OUT_N-1:0] IDLE = {OUT_N{!ON_LVL}};

  logic [ADDR_W-1:0] eff_addr;
  logic [OUT_N-1:0]  hot;
  logic              active;

  assign active = en_i && !en_n_i;

  addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .addr_i(addr_i), .hold_i(hold_i),
    .eff_addr_o(eff_addr)
  );

  onehot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(eff_addr), .en_i(active), .hot_o(hot)
  );

  sel_polarity #(.OUT_N(OUT_N), .POLARITY(POLARITY)) u_pol (
    .hot_i(hot), .sel_o(sel_o)
  );

  // R3: a deasserted enable idles every line
  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (en_n_i || !en_i) |-> (sel_o == IDLE));

  // R5: exactly one active line when enabled
  assert_single_line_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && !en_n_i) |-> ($countones(sel_o ^ IDLE) == 1));

  // R1: transparent path selects the live address
  assert_follow_live_R1: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && en_i && !en_n_i) |-> (sel_o[addr_i] == ON_LVL));
endmodule

// File: tb/latched_sel_decoder_tb.sv
module latched_sel_decoder_tb;
  import addr_dec_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic hold = 1'b0, en_n = 1'b0, en = 1'b1;
  logic [7:0] sel_hi, sel_lo;
  logic [4:0] wide_addr = '0;
  logic [31:0] wide_sel;
  int checks = 0, errors = 0;
  int held_m = 0;

  always #10 clk = ~clk;

  latched_sel_decoder #(.ADDR_W(3), .POLARITY(POL_HIGH)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .hold_i(hold),
    .en_n_i(en_n), .en_i(en), .sel_o(sel_hi));

  latched_sel_decoder #(.ADDR_W(3), .POLARITY(POL_LOW)) u_dut_lo (
    .clk(clk), .rst(rst), .addr_i(addr), .hold_i(hold),
    .en_n_i(en_n), .en_i(en), .sel_o(sel_lo));

  // R9 cascade: instance k enabled when wide_addr[4:3] == k
  for (genvar k = 0; k < 4; k++) begin : g_cas
    latched_sel_decoder #(.ADDR_W(3), .POLARITY(POL_HIGH)) u_cas (
      .clk(clk), .rst(rst), .addr_i(wide_addr[2:0]), .hold_i(1'b0),
      .en_n_i(wide_addr[3] != k[0]), .en_i(wide_addr[4] == k[1]),
      .sel_o(wide_sel[k*8 +: 8]));
  end

  // behavioural reference of the held address
  always @(posedge clk) begin
    if (rst) held_m <= 0;
    else if (!hold) held_m <= int'(addr);
  end

  function automatic logic [7:0] expect_hot(int a, bit on);
    logic [7:0] v = '0;
    if (on) v[a] = 1'b1;
    return v;
  endfunction

  task automatic step(input logic [2:0] a, input logic h, input logic n,
                      input logic e, input string tag);
    logic [7:0] exp_v;
    int use_a;
    @(negedge clk);
    addr = a; hold = h; en_n = n; en = e;
    #5;
    use_a = h ? held_m : int'(a);
    exp_v = expect_hot(use_a, e && !n);
    checks++;
    if (sel_hi !== exp_v) begin
      errors++;
      $display("FAIL %s high polarity: actual %b expected %b", tag, sel_hi, exp_v);
    end
    checks++;
    if (sel_lo !== ~exp_v) begin
      errors++;
      $display("FAIL %s R6 low polarity: actual %b expected %b", tag, sel_lo, ~exp_v);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset with hold high clears held address; outputs not forced
    rst = 1'b1;
    step(3'd5, 1'b1, 1'b0, 1'b1, "R8 reset-hold");
    step(3'd5, 1'b1, 1'b0, 1'b1, "R8 reset-hold");
    step(3'd3, 1'b0, 1'b0, 1'b1, "R8 reset-transparent");
    step(3'd7, 1'b1, 1'b0, 1'b1, "R8 reset-hold");
    @(negedge clk); rst = 1'b0;
    step(3'd6, 1'b1, 1'b0, 1'b1, "R8 held zero after reset");

    // R1 / R5: transparent sweep
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 1'b0, 1'b1, "R1 R5 sweep");
    for (int i = 7; i >= 0; i--) step(3'(i), 1'b0, 1'b0, 1'b1, "R5 reverse");

    // R2: capture 6 then hold while address moves
    step(3'd6, 1'b0, 1'b0, 1'b1, "R2 load");
    step(3'd1, 1'b1, 1'b0, 1'b1, "R2 hold");
    step(3'd3, 1'b1, 1'b0, 1'b1, "R2 hold");
    step(3'd0, 1'b1, 1'b0, 1'b1, "R2 hold");

    // R4: enables gate the held address immediately
    step(3'd2, 1'b1, 1'b1, 1'b1, "R4 en_n off");
    step(3'd2, 1'b1, 1'b0, 1'b1, "R4 reenable");
    step(3'd4, 1'b1, 1'b0, 1'b0, "R4 en off");
    step(3'd4, 1'b1, 1'b0, 1'b1, "R4 reenable");

    // R3: disabled in transparent mode, all combinations
    for (int i = 0; i < 8; i++) begin
      step(3'(i), 1'b0, 1'b1, 1'b1, "R3 en_n high");
      step(3'(i), 1'b0, 1'b0, 1'b0, "R3 en low");
      step(3'(i), 1'b0, 1'b1, 1'b0, "R3 both off");
    end

    // R7: demultiplex data on en with en_n held low
    for (int i = 0; i < 8; i++) begin
      step(3'(i), 1'b0, 1'b0, 1'b1, "R7 data one");
      step(3'(i), 1'b0, 1'b0, 1'b0, "R7 data zero");
    end

    // R9: cascade sweep
    for (int w = 0; w < 32; w++) begin
      @(negedge clk);
      wide_addr = 5'(w);
      #5;
      checks++;
      if (wide_sel !== (32'd1 << w)) begin
        errors++;
        $display("FAIL R9 cascade addr %0d: actual %h expected %h", w, wide_sel, 32'd1 << w);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule